// File: doc/BRIEF.md
# Event Interrupt and Soft-Reset Register Block

This block sits between a peripheral's event lines and one interrupt output to a processor. Each of seven event sources is watched for a rising edge. An edge latches a pending bit in a status register whether or not that source is enabled. Software reads the status register and clears bits by writing ones to them. A per-source enable mask and a single global gate together decide which pending bits can raise the registered interrupt line.

The same register space holds a reset register. A write of one exact key value starts a fixed-length reset pulse to the peripheral. While that pulse is active, the pending and enable registers are held clear. All register access goes through a plain single-cycle write strobe with an address. Read data is driven combinationally from the address, so there is no handshake and no back-pressure on this port.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0 and `periph_rst_o` is 0.
- R2: Status lives at offset 0x20, bits 6:0. The bits are, in order from 0: mode fault, slave mode fault, transmit empty, transmit underrun, receive full, receive overrun, transmit half empty. A 0-to-1 transition on `ev_i[i]` sets status bit i on the clock edge that samples it, whatever the enable value. An input that stays high does not set the bit again.
- R3: Writing to offset 0x20 clears exactly those status bits whose `wdata` bit is 1. All other status bits keep their value.
- R4: When a rising edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: The enable mask lives at offset 0x28, bits 6:0. It reads back what was written. Writing 0 masks every source.
- R6: The global gate is bit 31 of offset 0x1C. It reads back what was written.
- R7: `irq_o` equals, one cycle later, the global gate AND the OR over i of (status[i] AND enable[i]).
- R8: Only a write of exactly 0x0000000A to offset 0x40 asserts `periph_rst_o`. The pulse starts in the next cycle and lasts RST_CYCLES cycles (default 16). Any other value written there has no effect. A new key write during a pulse restarts the count.
- R9: While `periph_rst_o` is high, the status and enable registers are held at 0, and writes to them have no effect. The global gate is not affected.
- R10: Register bits that are not defined read as 0. The reset register always reads 0, and any offset outside the four listed reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | NUM_SRC | Peripheral event lines, edge-sensed |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | 8 | Byte offset for both write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_o | output | 1 | Registered interrupt request |
| periph_rst_o | output | 1 | Reset pulse to the peripheral |

## Verification
The assertions assume that `ev_i` is synchronous to `clk` and is never X after reset. They also assume that `wr_en`, `addr` and `wdata` hold steady through each clock edge. The stimulus drives every input on the falling edge from a fixed-seed random stream. That stream mixes event toggles with writes to the four defined offsets, to stray offsets, and to the reset register both with the key and with near-miss values. Directed sequences cover the cases that random draws reach rarely: an edge colliding with a clear, a level held high across a clear, and writes made during a reset pulse.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_GATE   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_KICK   = 8'h40;

  localparam int GATE_BIT = 31;
  localparam logic [DATA_W-1:0] KICK_KEY = 32'h0000_000A;

  typedef enum int {
    SRC_MODE_ERR   = 0,
    SRC_SLV_ERR    = 1,
    SRC_TX_DRAINED = 2,
    SRC_TX_STARVED = 3,
    SRC_RX_FILLED  = 4,
    SRC_RX_LOST    = 5,
    SRC_TX_HALF    = 6
  } src_idx_e;
endpackage

// File: rtl/evt_latch.sv
module evt_latch #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] clr_i,
  input  logic         hold_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] ev_prev;
  logic [N-1:0] rise;

  assign rise = ev_i & ~ev_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_prev  <= '0;
      status_o <= '0;
    end else begin
      ev_prev <= ev_i;
      if (hold_i) status_o <= '0;
      else        status_o <= (status_o & ~clr_i) | rise;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R2 R4
    edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i[i] && !ev_prev[i] && !hold_i) |=> status_o[i]);
    // R3
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !(ev_i[i] && !ev_prev[i])) |=> !status_o[i]);
  end

  // R9
  hold_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (status_o == '0));
endmodule

// File: rtl/rst_pulse.sv
module rst_pulse #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left <= '0;
    else if (fire_i)       left <= LOAD;
    else if (left != '0)   left <= left - 1'b1;
  end

  assign pulse_o = (left != '0);

  // R8
  fire_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> pulse_o);
  // R8
  rise_needs_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(fire_i));
endmodule

// File: rtl/irq_out.sv
module irq_out #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate_i,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= gate_i & |(pend_i & mask_i);
  end

  // R7
  gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_i |=> !irq_o);
  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_i & mask_i) == '0) |=> !irq_o);
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int NUM_SRC    = 7,
  parameter int RST_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  ev_i,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic                irq_o,
  output logic                periph_rst_o
);
  logic               wr_gate, wr_status, wr_mask, wr_kick;
  logic               gate_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] clr;

  assign wr_gate   = wr_en && (addr == OFF_GATE);
  assign wr_status = wr_en && (addr == OFF_STATUS);
  assign wr_mask   = wr_en && (addr == OFF_MASK);
  assign wr_kick   = wr_en && (addr == OFF_KICK) && (wdata == KICK_KEY);
  assign clr       = wr_status ? wdata[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      mask_q <= '0;
    end else begin
      if (wr_gate) gate_q <= wdata[GATE_BIT];
      if (periph_rst_o) mask_q <= '0;
      else if (wr_mask) mask_q <= wdata[NUM_SRC-1:0];
    end
  end

  evt_latch #(.N(NUM_SRC)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_i     (ev_i),
    .clr_i    (clr),
    .hold_i   (periph_rst_o),
    .status_o (status)
  );

  rst_pulse #(.CYCLES(RST_CYCLES)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (wr_kick),
    .pulse_o (periph_rst_o)
  );

  irq_out #(.N(NUM_SRC)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_i (gate_q),
    .pend_i (status),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFF_GATE:   rdata[GATE_BIT] = gate_q;
      OFF_STATUS: rdata[NUM_SRC-1:0] = status;
      OFF_MASK:   rdata[NUM_SRC-1:0] = mask_q;
      default:    rdata = '0;
    endcase
  end

  // R9
  mask_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst_o |=> (mask_q == '0));
  // R5
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && !periph_rst_o) |=> (mask_q == $past(wdata[NUM_SRC-1:0])));
  // R6
  gate_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_gate |=> (gate_q == $past(wdata[GATE_BIT])));
endmodule

// File: tb/sim_evt_irq_ctrl.sv
module sim_evt_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 7;
  localparam int RSTC = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] ev_i = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq_o;
  logic          periph_rst_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [NS-1:0] m_status, m_mask, m_prev;
  logic          m_gate, m_irq;
  int            m_cnt;

  evt_irq_ctrl #(.NUM_SRC(NS), .RST_CYCLES(RSTC)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .periph_rst_o(periph_rst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h1C:   return {m_gate, 31'b0};
      8'h20:   return {25'b0, m_status};
      8'h28:   return {25'b0, m_mask};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    case (a)
      8'h1C:   return "R6";
      8'h20:   return "R2";
      8'h28:   return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_status = '0; m_mask = '0; m_prev = '0; m_gate = 0; m_irq = 0; m_cnt = 0;
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input logic [NS-1:0] ev);
    logic [NS-1:0] rise, clr;
    logic hold;
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; ev_i = ev;
    #1;
    check(rd_tag(a), rdata, exp_rd(a));
    check("R7", {31'b0, irq_o}, {31'b0, m_irq});
    check("R8", {31'b0, periph_rst_o}, {31'b0, m_cnt != 0});
    @(posedge clk);
    rise = ev & ~m_prev;
    hold = (m_cnt != 0);
    clr  = (we && a == 8'h20) ? d[NS-1:0] : '0;
    m_irq = m_gate & |(m_status & m_mask);
    m_status = hold ? '0 : ((m_status & ~clr) | rise);
    m_mask = hold ? '0 : ((we && a == 8'h28) ? d[NS-1:0] : m_mask);
    if (we && a == 8'h1C) m_gate = d[31];
    if (we && a == 8'h40 && d == 32'h0000_000A) m_cnt = RSTC;
    else if (m_cnt > 0) m_cnt = m_cnt - 1;
    m_prev = ev;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [NS-1:0] ev;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every register and output
    step(0, 8'h1C, 0, '0); step(0, 8'h20, 0, '0);
    step(0, 8'h28, 0, '0); step(0, 8'h40, 0, '0);
    #1; check("R1", {30'b0, irq_o, periph_rst_o}, 32'h0);

    // R2: edge sets status with mask closed; R7 stays quiet
    step(1, 8'h1C, 32'h8000_0000, '0);
    step(1, 8'h28, 32'h0, 7'h10);
    step(0, 8'h20, 0, 7'h10);
    #1; check("R2", rdata, 32'h10);
    step(0, 8'h20, 0, 7'h10);
    #1; check("R7", {31'b0, irq_o}, 32'h0);

    // R3: clear while level stays high, no re-set
    step(1, 8'h20, 32'h10, 7'h10);
    step(0, 8'h20, 0, 7'h10);
    #1; check("R3", rdata, 32'h0);

    // R4: edge and clear in the same cycle
    step(0, 8'h20, 0, 7'h00);
    step(1, 8'h20, 32'h04, 7'h04);
    step(0, 8'h20, 0, 7'h04);
    #1; check("R4", rdata, 32'h04);

    // R5 R7: open mask, irq one cycle later
    step(1, 8'h28, 32'h04, 7'h04);
    step(0, 8'h28, 0, 7'h04);
    step(0, 8'h28, 0, 7'h04);
    #1; check("R7", {31'b0, irq_o}, 32'h1);

    // R8: near-miss value ignored
    step(1, 8'h40, 32'h0000_000B, 7'h04);
    step(0, 8'h40, 0, 7'h04);
    #1; check("R8", {31'b0, periph_rst_o}, 32'h0);
    // R8 R9: key write, then writes during pulse ignored
    step(1, 8'h40, 32'h0000_000A, 7'h04);
    step(1, 8'h28, 32'h7F, 7'h00);
    step(1, 8'h20, 32'h0, 7'h7F);
    step(0, 8'h28, 0, 7'h7F);
    #1; check("R9", rdata, 32'h0);
    for (int i = 0; i < RSTC; i++) step(0, 8'h20, 0, 7'h00);
    #1; check("R8", {31'b0, periph_rst_o}, 32'h0);
    step(0, 8'h1C, 0, 7'h00);
    #1; check("R9", rdata, 32'h8000_0000);

    // R10: stray offset reads 0
    step(0, 8'h24, 0, 7'h00);
    #1; check("R10", rdata, 32'h0);

    // constrained random phase
    void'($urandom(32'd1234));
    ev = '0;
    for (int n = 0; n < 4000; n++) begin
      logic we;
      logic [7:0] a;
      logic [31:0] d;
      int sel;
      if ($urandom_range(0, 3) == 0) ev = ev ^ NS'($urandom);
      we  = ($urandom_range(0, 9) < 3);
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1, 2: a = 8'h20;
        3, 4:    a = 8'h28;
        5, 6:    a = 8'h1C;
        7:       a = 8'h40;
        default: a = 8'($urandom);
      endcase
      d = $urandom;
      if (a == 8'h40 && $urandom_range(0, 7) == 0) d = 32'h0000_000A;
      step(we, a, d, ev);
    end

    finish_run();
  end
endmodule